// File: doc/BRIEF.md
# Hysteretic Peak and Valley Detector

This block watches a stream of unsigned 10-bit samples taken from a roughly sinusoidal waveform and reports every turning point it can confirm. It alternates between hunting for a maximum and hunting for a minimum. A candidate extremum counts only once the signal has moved back away from it by more than a fixed margin of 10 codes. Small noise ripple near the top or bottom of a cycle therefore cannot produce false events.

Each confirmed maximum raises a one-cycle pulse and presents its value. Each confirmed minimum does the same on a separate pair of outputs. The two values stay on the outputs between events, so a downstream amplitude stage can read them at leisure. The current search direction is also visible.

Top module: `pkv_detector`

## Requirements
- R1: While rst_ni is low and right after it is released, peak_o and valley_o are 0, peak_val_o and valley_val_o are 0, and seek_min_o is 0 (searching for a maximum).
- R2: The first valid sample after reset loads both the running maximum and the running minimum, and produces no event.
- R3: While searching for a maximum (seek_min_o = 0), a valid sample above the running maximum replaces it. While searching for a minimum (seek_min_o = 1), a valid sample below the running minimum replaces it.
- R4: While searching for a maximum, a valid sample strictly less than the running maximum minus 10 confirms a peak. In the cycle after that sample, peak_o is 1, peak_val_o shows the running maximum, and seek_min_o becomes 1.
- R5: While searching for a minimum, a valid sample strictly greater than the running minimum plus 10 confirms a valley. In the cycle after that sample, valley_o is 1, valley_val_o shows the running minimum, and seek_min_o becomes 0.
- R6: The sample that confirms a peak becomes the new running minimum. The sample that confirms a valley becomes the new running maximum.
- R7: The thresholds saturate rather than wrap. A running maximum below 10 cannot confirm a peak, because its lower threshold is clamped to 0.
- R8: A sample presented with smp_valid_i = 0 has no effect on any output or on the running state.
- R9: peak_o and valley_o are single-cycle pulses and are never high together. peak_val_o and valley_val_o hold their values until the next event of the same kind.
- R10: The margin is exactly 10 codes. A sample equal to the running maximum minus 10, or equal to the running minimum plus 10, confirms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | 10 | Unsigned sample value |
| peak_o | output | 1 | One-cycle pulse when a maximum is confirmed |
| peak_val_o | output | 10 | Value of the last confirmed maximum |
| valley_o | output | 1 | One-cycle pulse when a minimum is confirmed |
| valley_val_o | output | 10 | Value of the last confirmed minimum |
| seek_min_o | output | 1 | 1 while searching for a minimum, 0 while searching for a maximum |

## Verification
The bench targets the threshold edge by placing samples exactly on the running extremum minus or plus 10 and then one code beyond it. An off-by-one comparison would fire one code early or miss the confirming sample.

Strobe-low samples are sent with values that would otherwise trigger an event. A design that ignored the strobe would emit a spurious pulse or flip direction.

A reset followed by priming with a value below 10 probes the saturated lower threshold. Wrapping arithmetic there would confirm a peak on a sample of zero.

A seeded random walk with noise, compared every cycle against a bench model, catches a running value that is not restarted from the confirming sample. Such a fault shifts every later reported extremum.

// File: rtl/pkv_pkg.sv
package pkv_pkg;
  typedef enum logic {
    SEEK_MAX = 1'b0,
    SEEK_MIN = 1'b1
  } seek_e;
endpackage

// File: rtl/pkv_margin_reg.sv
module pkv_margin_reg #(
  parameter int W      = 10,
  parameter int MARGIN = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] margin_o
);
  logic [W-1:0] margin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) margin_q <= W'(MARGIN);
    else         margin_q <= margin_q;
  end

  assign margin_o = margin_q;
endmodule

// File: rtl/pkv_sat_bound.sv
// Clamped threshold: base + margin (UPWARD) or base - margin.
module pkv_sat_bound #(
  parameter int W      = 10,
  parameter bit UPWARD = 1'b0
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] margin_i,
  output logic [W-1:0] bound_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  generate
    if (UPWARD) begin : g_up
      logic [W:0] sum;
      always_comb begin
        sum     = {1'b0, base_i} + {1'b0, margin_i};
        bound_o = sum[W] ? TOP : sum[W-1:0];
      end
    end else begin : g_dn
      always_comb begin
        bound_o = (base_i < margin_i) ? '0 : base_i - margin_i;
      end
    end
  endgenerate
endmodule

// File: rtl/pkv_tracker.sv
module pkv_tracker
  import pkv_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] smp_i,
  input  logic [W-1:0] margin_i,
  output logic         hit_peak_o,
  output logic         hit_valley_o,
  output logic [W-1:0] hit_val_o,
  output seek_e        seek_o
);
  logic         primed_q;
  seek_e        seek_q, seek_d;
  logic [W-1:0] run_max_q, run_max_d;
  logic [W-1:0] run_min_q, run_min_d;
  logic [W-1:0] max_floor, min_ceil;

  pkv_sat_bound #(.W(W), .UPWARD(1'b0)) u_floor (
    .base_i(run_max_q), .margin_i(margin_i), .bound_o(max_floor)
  );
  pkv_sat_bound #(.W(W), .UPWARD(1'b1)) u_ceil (
    .base_i(run_min_q), .margin_i(margin_i), .bound_o(min_ceil)
  );

  always_comb begin
    seek_d       = seek_q;
    run_max_d    = run_max_q;
    run_min_d    = run_min_q;
    hit_peak_o   = 1'b0;
    hit_valley_o = 1'b0;
    hit_val_o    = '0;
    if (valid_i) begin
      if (!primed_q) begin
        run_max_d = smp_i;
        run_min_d = smp_i;
      end else if (seek_q == SEEK_MAX) begin
        if (smp_i > run_max_q) begin
          run_max_d = smp_i;
        end else if (smp_i < max_floor) begin
          hit_peak_o = 1'b1;
          hit_val_o  = run_max_q;
          run_min_d  = smp_i;
          seek_d     = SEEK_MIN;
        end
      end else begin
        if (smp_i < run_min_q) begin
          run_min_d = smp_i;
        end else if (smp_i > min_ceil) begin
          hit_valley_o = 1'b1;
          hit_val_o    = run_min_q;
          run_max_d    = smp_i;
          seek_d       = SEEK_MAX;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q  <= 1'b0;
      seek_q    <= SEEK_MAX;
      run_max_q <= '0;
      run_min_q <= '0;
    end else begin
      if (valid_i) primed_q <= 1'b1;
      seek_q    <= seek_d;
      run_max_q <= run_max_d;
      run_min_q <= run_min_d;
    end
  end

  assign seek_o = seek_q;
endmodule

// File: rtl/pkv_detector.sv
module pkv_detector
  import pkv_pkg::*;
#(
  parameter int W      = 10,
  parameter int MARGIN = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         smp_valid_i,
  input  logic [W-1:0] smp_i,
  output logic         peak_o,
  output logic [W-1:0] peak_val_o,
  output logic         valley_o,
  output logic [W-1:0] valley_val_o,
  output logic         seek_min_o
);
  logic [W-1:0] margin;
  logic         hit_peak, hit_valley;
  logic [W-1:0] hit_val;
  seek_e        seek;

  pkv_margin_reg #(.W(W), .MARGIN(MARGIN)) u_margin (
    .clk_i(clk_i), .rst_ni(rst_ni), .margin_o(margin)
  );

  pkv_tracker #(.W(W)) u_trk (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(smp_valid_i), .smp_i(smp_i),
    .margin_i(margin), .hit_peak_o(hit_peak), .hit_valley_o(hit_valley),
    .hit_val_o(hit_val), .seek_o(seek)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_o       <= 1'b0;
      valley_o     <= 1'b0;
      peak_val_o   <= '0;
      valley_val_o <= '0;
    end else begin
      peak_o   <= hit_peak;
      valley_o <= hit_valley;
      if (hit_peak)   peak_val_o   <= hit_val;
      if (hit_valley) valley_val_o <= hit_val;
    end
  end

  assign seek_min_o = (seek == SEEK_MIN);
endmodule

// File: rtl/pkv_detector_chk.sv
module pkv_detector_chk #(
  parameter int W      = 10,
  parameter int MARGIN = 10
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         smp_valid_i,
  input logic [W-1:0] smp_i,
  input logic         peak_o,
  input logic [W-1:0] peak_val_o,
  input logic         valley_o,
  input logic [W-1:0] valley_val_o,
  input logic         seek_min_o
);
  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(peak_o && valley_o));
  p_peak_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peak_o |=> !peak_o);
  p_peak_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !peak_o |-> $stable(peak_val_o));
  p_valley_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valley_o |-> $stable(valley_val_o));
  p_peak_dir_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seek_min_o) |-> peak_o);
  p_valley_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(seek_min_o) |-> valley_o);
  p_peak_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !peak_o && !valley_o);
  p_peak_margin_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peak_o |-> ({1'b0, peak_val_o} > {1'b0, $past(smp_i)} + (W+1)'(MARGIN)));
  p_valley_margin_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valley_o |-> ({1'b0, $past(smp_i)} > {1'b0, valley_val_o} + (W+1)'(MARGIN)));
endmodule

bind pkv_detector pkv_detector_chk #(.W(W), .MARGIN(MARGIN)) u_chk (.*);

// File: tb/pkv_detector_bench.sv
module pkv_detector_bench;
  localparam int W = 10;
  localparam int MARGIN = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic smp_valid_i = 1'b0;
  logic [W-1:0] smp_i = '0;
  logic peak_o, valley_o, seek_min_o;
  logic [W-1:0] peak_val_o, valley_val_o;

  always #4 clk = ~clk;

  pkv_detector #(.W(W), .MARGIN(MARGIN)) u_pkv_detector (
    .clk_i(clk), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i), .smp_i(smp_i),
    .peak_o(peak_o), .peak_val_o(peak_val_o), .valley_o(valley_o),
    .valley_val_o(valley_val_o), .seek_min_o(seek_min_o)
  );

  int checks = 0, fails = 0, n_peaks = 0, n_valleys = 0;
  bit done = 0;

  // bench reference state
  bit m_primed, m_seek, e_peak, e_valley;
  int m_max, m_min, e_pv, e_vv;

  function automatic void model_reset();
    m_primed = 0; m_seek = 0; m_max = 0; m_min = 0;
    e_peak = 0; e_valley = 0; e_pv = 0; e_vv = 0;
  endfunction

  function automatic void model_step(bit v, int s);
    e_peak = 0; e_valley = 0;
    if (!v) return;
    if (!m_primed) begin
      m_primed = 1; m_max = s; m_min = s;
    end else if (!m_seek) begin
      if (s > m_max) m_max = s;
      else if (s < m_max - MARGIN) begin
        e_peak = 1; e_pv = m_max; m_seek = 1; m_min = s;
      end
    end else begin
      if (s < m_min) m_min = s;
      else if (s > m_min + MARGIN) begin
        e_valley = 1; e_vv = m_min; m_seek = 0; m_max = s;
      end
    end
  endfunction

  task automatic compare(string tag);
    checks++;
    if (peak_o !== e_peak || valley_o !== e_valley || seek_min_o !== m_seek ||
        peak_val_o !== W'(e_pv) || valley_val_o !== W'(e_vv)) begin
      fails++;
      $display("FAIL %s: got pk=%0b pv=%0d vl=%0b vv=%0d dir=%0b exp pk=%0b pv=%0d vl=%0b vv=%0d dir=%0b",
               tag, peak_o, peak_val_o, valley_o, valley_val_o, seek_min_o,
               e_peak, e_pv, e_valley, e_vv, m_seek);
    end
  endtask

  // drive at negedge, result visible after the next posedge, checked at next negedge
  task automatic apply(bit v, int s, string tag);
    smp_valid_i = v;
    smp_i = W'(s);
    model_step(v, s);
    @(negedge clk);
    if (e_peak) n_peaks++;
    if (e_valley) n_valleys++;
    compare(tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; smp_valid_i = 1'b0; smp_i = '0;
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1 after release");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int level, dir, amp, noise, v;
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();

    apply(0, 5, "R8 strobe low before priming");
    apply(1, 500, "R2 first sample primes");
    apply(1, 490, "R10 equal to max-10 no peak");
    apply(1, 489, "R4 peak confirmed");
    apply(1, 499, "R10 equal to min+10 no valley");
    apply(1, 480, "R3 min lowered");
    apply(0, 900, "R8 strobe low ignored");
    apply(1, 491, "R5 valley confirmed");
    apply(1, 480, "R6 max restarted from valley sample");
    apply(0, 0, "R9 values held");
    apply(1, 1020, "R6 min restarted from peak sample");
    apply(1, 1009, "R4 peak at high value");

    do_reset();
    apply(1, 6, "R2 prime low");
    apply(1, 0, "R7 clamped floor no peak");
    apply(1, 0, "R7 clamped floor no peak again");
    apply(1, 20, "R3 max raised");
    apply(1, 9, "R4 peak after raise");

    // seeded random triangle wave with noise
    level = 512; dir = 1; amp = 200;
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) amp = 20 + int'($urandom_range(400));
      level += dir * (1 + int'($urandom_range(7)));
      if (level > 512 + amp) dir = -1;
      if (level < 512 - amp) dir = 1;
      noise = int'($urandom_range(16)) - 8;
      v = level + noise;
      if (v < 0) v = 0;
      if (v > 1023) v = 1023;
      apply($urandom_range(9) != 0, v, m_seek ? "R5 random" : "R3 R4 random");
    end

    checks++;
    if (n_peaks < 5 || n_valleys < 5) begin
      fails++;
      $display("FAIL R4 R5 event count: got peaks=%0d valleys=%0d expected >=5 each",
               n_peaks, n_valleys);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule